// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives a bus host byte access to a small bank of internal registers. It samples SCL and SDA in the system clock domain and finds Start and Stop conditions. It answers a 7-bit device address whose six upper bits are fixed and whose lowest bit comes from a strap pin. Registers are chosen through a memory address pointer (MAP) byte. Bit 7 of that byte turns on auto-increment and bits 6:0 hold the pointer.

A write transfer sends the device address, then the MAP byte, then any number of data bytes that land in consecutive or repeated registers. A read transfer cannot load the pointer. To read, the host first sends a write that it stops right after the MAP byte is acknowledged. It then starts a read, which returns data from the stored pointer. The register contents are driven out as a flat bus for the rest of the chip. SDA is driven through an open-drain enable: when the enable is high the line is pulled low.

Top module: `i2cRegPort`

## Requirements
- R1: A Stop (SDA rising while SCL is high) ends any transfer and releases SDA on the next cycle. The block then ignores SCL activity until a Start (SDA falling while SCL is high).
- R2: After a Start, the first byte holds address bits 7:1 and an R/W bit in bit 0, where 1 means read. The block acknowledges by pulling SDA low during the ninth clock only when bits 7:1 equal 100111 followed by the strap pin level.
- R3: When the address does not match, SDA stays released for the acknowledge and for every later byte of that transfer.
- R4: In a write transfer, the byte after the address loads the pointer: bit 7 is the increment flag and bits 6:0 are the register index. The block acknowledges this byte.
- R5: Every later byte of a write transfer is acknowledged. It is stored in the register the pointer selects, and the result appears on the matching 8-bit slice of `regBank`, with register 0 in bits 7:0.
- R6: When the increment flag is 0, the pointer does not move, so successive write bytes overwrite the same register. When it is 1, each write byte advances the pointer by one.
- R7: The pointer loaded by a write survives a Stop placed right after the pointer byte's acknowledge. A later read transfer returns that register, MSB first.
- R8: In a read transfer with the increment flag set, each byte sent advances the pointer. With the flag clear, every byte returns the same register.
- R9: When the host does not acknowledge a read byte, the block stops transmitting and keeps SDA released until the next Start or Stop.
- R10: A pointer at or above the register count (8) selects no register. Writes through it are acknowledged but change nothing, and reads through it return 0x00.
- R11: Incrementing the pointer from the last register (index 7) wraps it to index 0.
- R12: Out of reset SDA is released and all registers read 0x00. The SDA enable changes only in the cycle after a detected SCL falling edge, or after a Start or Stop.
- R13: A repeated Start in the middle of a transfer restarts address matching, even after a non-matching address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | I2C clock line as seen at the pad |
| sdaIn | input | 1 | I2C data line as seen at the pad |
| addrStrap | input | 1 | Strap level giving device address bit 0 |
| sdaOe | output | 1 | Open-drain enable; 1 pulls SDA low |
| regBank | output | NUM_REGS*8 | Register contents, register i in bits 8i+7:8i |

## Verification
The bench builds the block with its defaults: eight registers, two synchronizer stages, the fixed upper address 100111, and the strap tied high. A register count of eight brings both pointer corner cases within a few bytes of traffic. A pointer byte of 0x87 reaches the wrap from index 7 to 0, and 0x0A reaches a pointer past the last register. With the strap tied high, an address that differs only in its strap bit is the nearest mismatch the bench can send, and it exercises the reject path and the repeated Start that recovers from it.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_ADDR,
    ST_RX_MAP,
    ST_RX_DATA,
    ST_ACK,
    ST_TX,
    ST_HOST_ACK,
    ST_IGNORE
  } tgtState_e;

  // Strobes from the control FSM into the datapath, one cycle each
  typedef struct packed {
    logic shiftIn;     // capture sampled SDA into receive shifter
    logic loadMap;     // received byte becomes the pointer byte
    logic writeReg;    // received byte goes to the selected register
    logic loadTx;      // fetch the selected register into transmit shifter
    logic shiftTx;     // present the next transmit bit
    logic advancePtr;  // step pointer if increment flag set
  } dpStrobes_t;

endpackage

// File: rtl/i2cLineSync.sv
module i2cLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclChain;
  logic [STAGES-1:0] sdaChain;
  logic sclPrev;
  logic sdaPrev;
  logic sclS;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= scl;
          sdaChain <= sdaIn;
        end
      end
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[STAGES-2:0], scl};
          sdaChain <= {sdaChain[STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclChain[STAGES-1];
  assign sdaS = sdaChain[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/i2cTargetCtrl.sv
module i2cTargetCtrl
  import i2cRegPkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b100111
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaS,
  input  logic       addrStrap,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobes_t stb,
  output logic       sdaOe
);

  tgtState_e state;
  tgtState_e afterAck;
  logic [2:0] bitCnt;
  logic       byteFull;
  logic       hostNack;
  logic       addrHit;
  logic       quiet;
  logic       rxPhase;
  logic       byteDone;

  assign addrHit  = (rxByte[7:1] == {ADDR_HI, addrStrap});
  assign quiet    = ~startDet & ~stopDet;
  assign rxPhase  = (state == ST_RX_ADDR) | (state == ST_RX_MAP) | (state == ST_RX_DATA);
  assign byteDone = rxPhase & sclFall & byteFull & quiet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_IDLE;
      bitCnt   <= '0;
      byteFull <= 1'b0;
      hostNack <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      byteFull <= 1'b0;
    end else if (startDet) begin
      state    <= ST_RX_ADDR;
      bitCnt   <= '0;
      byteFull <= 1'b0;
    end else begin
      case (state)
        ST_RX_ADDR, ST_RX_MAP, ST_RX_DATA: begin
          if (sclRise) begin
            byteFull <= (bitCnt == 3'd7);
            bitCnt   <= bitCnt + 3'd1;
          end else if (sclFall && byteFull) begin
            byteFull <= 1'b0;
            if (state == ST_RX_ADDR) begin
              if (addrHit) begin
                state    <= ST_ACK;
                afterAck <= rxByte[0] ? ST_TX : ST_RX_MAP;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              state    <= ST_ACK;
              afterAck <= ST_RX_DATA;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            state  <= afterAck;
            bitCnt <= '0;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 3'd7) begin
              state  <= ST_HOST_ACK;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 3'd1;
            end
          end
        end
        ST_HOST_ACK: begin
          if (sclRise) begin
            hostNack <= sdaS;
          end else if (sclFall) begin
            state <= hostNack ? ST_IGNORE : ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stb            = '0;
    stb.shiftIn    = rxPhase & sclRise & quiet;
    stb.loadMap    = byteDone & (state == ST_RX_MAP);
    stb.writeReg   = byteDone & (state == ST_RX_DATA);
    stb.loadTx     = quiet & sclFall &
                     (((state == ST_ACK) & (afterAck == ST_TX)) |
                      ((state == ST_HOST_ACK) & ~hostNack));
    stb.shiftTx    = quiet & sclFall & (state == ST_TX) & (bitCnt != 3'd7);
    stb.advancePtr = stb.writeReg | stb.loadTx;
  end

  assign sdaOe = (state == ST_ACK) | ((state == ST_TX) & ~txBit);

endmodule

// File: rtl/i2cTargetData.sv
module i2cTargetData
  import i2cRegPkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobes_t            stb,
  input  logic                  sdaS,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [NUM_REGS*8-1:0] regBank
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [6:0] LAST_IDX = 7'(NUM_REGS - 1);

  logic [7:0] rxShift;
  logic [7:0] txShift;
  logic       incFlag;
  logic [6:0] ptr;
  logic       inRange;
  logic [6:0] nextPtr;
  logic [7:0] rdData;
  logic [7:0] regs [NUM_REGS];

  assign inRange = (ptr <= LAST_IDX);
  assign nextPtr = (ptr == LAST_IDX) ? 7'd0 : ptr + 7'd1;
  assign rdData  = inRange ? regs[ptr[IDX_W-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      incFlag <= 1'b0;
      ptr     <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaS};
      if (stb.loadTx) txShift <= rdData;
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b1};
      if (stb.loadMap) begin
        incFlag <= rxShift[7];
        ptr     <= rxShift[6:0];
      end else if (stb.advancePtr && incFlag) begin
        ptr <= nextPtr;
      end
    end
  end

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regs[i] <= '0;
        else if (stb.writeReg && inRange && (ptr[IDX_W-1:0] == IDX_W'(i)))
          regs[i] <= rxShift;
      end
      assign regBank[i*8 +: 8] = regs[i];
    end
  endgenerate

  assign rxByte = rxShift;
  assign txBit  = txShift[7];

endmodule

// File: rtl/i2cRegPort.sv
module i2cRegPort
  import i2cRegPkg::*;
#(
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b100111
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  scl,
  input  logic                  sdaIn,
  input  logic                  addrStrap,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regBank
);

  logic       sdaS;
  logic       sclRise;
  logic       sclFall;
  logic       startDet;
  logic       stopDet;
  logic [7:0] rxByte;
  logic       txBit;
  dpStrobes_t stb;

  i2cLineSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn),
    .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cTargetCtrl #(.ADDR_HI(ADDR_HI)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS),
    .addrStrap(addrStrap), .rxByte(rxByte), .txBit(txBit),
    .stb(stb), .sdaOe(sdaOe)
  );

  i2cTargetData #(.NUM_REGS(NUM_REGS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaS(sdaS),
    .rxByte(rxByte), .txBit(txBit), .regBank(regBank)
  );

endmodule

// File: rtl/i2cRegPortChk.sv
module i2cRegPortChk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sdaOe,
  input logic                  sclFall,
  input logic                  startDet,
  input logic                  stopDet,
  input logic                  wrStrobe,
  input logic [NUM_REGS*8-1:0] regBank
);

  // R12
  oe_rise_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(sclFall));

  // R12
  oe_fall_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> ($past(sclFall) || $past(startDet) || $past(stopDet)));

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  // R13
  start_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);

  // R5
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |=> $stable(regBank));

endmodule

bind i2cRegPort i2cRegPortChk #(.NUM_REGS(NUM_REGS)) uChk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclFall(sclFall),
  .startDet(startDet), .stopDet(stopDet), .wrStrobe(stb.writeReg),
  .regBank(regBank)
);

// File: tb/tb_i2cRegPort.sv
module tb_i2cRegPort;

  localparam int NREG = 8;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic hostSdaLow = 1'b0;
  logic sdaOe;
  logic sdaLine;
  logic [NREG*8-1:0] regBank;
  logic [7:0] expRegs [NREG];
  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign sdaLine = ~(sdaOe | hostSdaLow);

  i2cRegPort dut (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaLine),
    .addrStrap(1'b1), .sdaOe(sdaOe), .regBank(regBank)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    hostSdaLow = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    hostSdaLow = 1'b1; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    hostSdaLow = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    hostSdaLow = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      hostSdaLow = ~b[i]; waitQ();
      scl = 1'b1; waitQ(); waitQ();
      scl = 1'b0; waitQ();
    end
    hostSdaLow = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    acked = (sdaLine == 1'b0);
    waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic recvByte(input bit hostAck, output logic [7:0] b);
    hostSdaLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      scl = 1'b1; waitQ();
      b[i] = sdaLine;
      waitQ();
      scl = 1'b0; waitQ();
    end
    hostSdaLow = hostAck; waitQ();
    scl = 1'b1; waitQ(); waitQ();
    scl = 1'b0; waitQ();
    hostSdaLow = 1'b0;
  endtask

  task automatic checkBank(input string tag);
    logic [NREG*8-1:0] e;
    for (int i = 0; i < NREG; i++) e[i*8 +: 8] = expRegs[i];
    check(regBank == e, tag, 64'(regBank), 64'(e));
  endtask

  // write transfer: address, pointer byte, data bytes
  task automatic writeSeq(input logic [7:0] mapByte, input logic [7:0] d [], input string tag);
    bit a;
    busStart();
    sendByte(8'h9E, a);
    check(a, {tag, " R2 address ack"}, 64'(a), 64'd1);
    sendByte(mapByte, a);
    check(a, {tag, " R4 pointer ack"}, 64'(a), 64'd1);
    foreach (d[i]) begin
      sendByte(d[i], a);
      check(a, {tag, " R5 data ack"}, 64'(a), 64'd1);
    end
    busStop();
  endtask

  task automatic t_reset();
    check(sdaOe == 1'b0, "R12 reset sdaOe", 64'(sdaOe), 64'd0);
    check(regBank == '0, "R12 reset regs", 64'(regBank), 64'd0);
  endtask

  task automatic t_writeInc();
    writeSeq(8'h82, '{8'h11, 8'h22, 8'h33}, "inc");
    expRegs[2] = 8'h11; expRegs[3] = 8'h22; expRegs[4] = 8'h33;
    checkBank("R6 R5 auto-increment write");
  endtask

  task automatic t_writeNoInc();
    writeSeq(8'h05, '{8'hA5, 8'h5A}, "noinc");
    expRegs[5] = 8'h5A;
    checkBank("R6 fixed pointer write");
  endtask

  task automatic t_readInc();
    bit a;
    logic [7:0] b;
    writeSeq(8'h83, '{}, "preamble");
    busStart();
    sendByte(8'h9F, a);
    check(a, "R2 read address ack", 64'(a), 64'd1);
    recvByte(1'b1, b);
    check(b == 8'h22, "R7 read from stored pointer", 64'(b), 64'h22);
    recvByte(1'b0, b);
    check(b == 8'h33, "R8 read increments", 64'(b), 64'h33);
    waitQ();
    check(sdaOe == 1'b0, "R9 released after nack", 64'(sdaOe), 64'd0);
    scl = 1'b1; waitQ(); scl = 1'b0; waitQ();
    check(sdaOe == 1'b0, "R9 still released", 64'(sdaOe), 64'd0);
    busStop();
  endtask

  task automatic t_readNoInc();
    bit a;
    logic [7:0] b;
    writeSeq(8'h02, '{}, "preamble2");
    busStart();
    sendByte(8'h9F, a);
    recvByte(1'b1, b);
    check(b == 8'h11, "R8 no-inc first read", 64'(b), 64'h11);
    recvByte(1'b0, b);
    check(b == 8'h11, "R8 no-inc repeat read", 64'(b), 64'h11);
    busStop();
  endtask

  task automatic t_wrap();
    writeSeq(8'h87, '{8'h77, 8'h88}, "wrap");
    expRegs[7] = 8'h77; expRegs[0] = 8'h88;
    checkBank("R11 wrap 7 to 0");
  endtask

  task automatic t_outOfRange();
    bit a;
    logic [7:0] b;
    writeSeq(8'h0A, '{8'hFF}, "oob");
    checkBank("R10 write beyond last ignored");
    busStart();
    sendByte(8'h9F, a);
    recvByte(1'b0, b);
    check(b == 8'h00, "R10 read beyond last", 64'(b), 64'h00);
    busStop();
  endtask

  task automatic t_badAddr();
    bit a;
    busStart();
    sendByte(8'h9C, a);
    check(!a, "R3 mismatched address nack", 64'(a), 64'd0);
    sendByte(8'h01, a);
    check(!a, "R3 later byte nack", 64'(a), 64'd0);
    sendByte(8'h66, a);
    busStop();
    checkBank("R3 regs untouched");
    check(sdaOe == 1'b0, "R1 released after stop", 64'(sdaOe), 64'd0);
  endtask

  task automatic t_repStart();
    bit a;
    busStart();
    sendByte(8'h9C, a);
    check(!a, "R13 first address rejected", 64'(a), 64'd0);
    busStart();
    sendByte(8'h9E, a);
    check(a, "R13 repeated start matches", 64'(a), 64'd1);
    sendByte(8'h01, a);
    sendByte(8'h44, a);
    busStop();
    expRegs[1] = 8'h44;
    checkBank("R13 write after repeated start");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) expRegs[i] = 8'h00;
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_writeInc();
    t_writeNoInc();
    t_readInc();
    t_readNoInc();
    t_wrap();
    t_outOfRange();
    t_badAddr();
    t_repStart();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule